// File: doc/BRIEF.md
# Region-Based Address Translation Walker

This block turns a 48-bit virtual pointer into a physical address for a pointer-chasing engine that sits next to memory. The upper seven bits of the pointer select one of a few software-defined regions held in an on-chip table, so finding the region costs no memory access. Each region owns a flat table that is indexed directly by twenty middle bits of the pointer, and a flat entry points at a 4 KB last-level table indexed by nine more bits. Its entry gives the 4 KB frame, and the low twelve bits of the pointer are appended unchanged. A full walk therefore costs exactly two memory reads.

Requests arrive with a valid/ready handshake, one at a time. Table reads go out on a read port that allows only one read in flight. The result comes back as a one-cycle response that carries either a physical address or a fault flag. A missing region, or an invalid entry at either level, stops the walk at once. Software loads the region table through a write port that only takes effect while the walker is idle.

Top module: `xw_region_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. After a request is accepted it stays low until the cycle after the response pulse, and it is high again in that cycle.
- R2: The region is found by comparing pointer bits [47:41] with the tag of every valid region entry, and the lowest-numbered matching entry wins. With no match the response is a fault, no memory read is issued, and `rsp_valid` rises two cycles after the accepting clock edge.
- R3: The first memory read goes to the matched entry's base plus pointer bits [40:21] times 8.
- R4: In a flat entry, bit 0 is the valid flag and bits [39:12] give the base of the last-level table, with the low 12 bits taken as zero. If the flag is clear, the walk ends with a fault after that single read.
- R5: The second memory read goes to the last-level table base plus pointer bits [20:12] times 8.
- R6: In a last-level entry, bit 0 is the valid flag and bits [39:12] are the frame number. When the flag is set, the response address is {frame, pointer bits [11:0]}. When it is clear, the response is a fault.
- R7: `rsp_valid` is a single-cycle pulse, one per accepted request. On a fault, `rsp_pa` is zero.
- R8: `mem_req_valid` is held, with a stable address, until `mem_req_ready` is seen high. Only one read is in flight at a time. A `mem_rsp_valid` that arrives while no read is in flight is ignored.
- R9: A region-table write (`cfg_we`) takes effect only in a cycle where `req_ready` is high, and is dropped otherwise. A write made in the same cycle a request is accepted is already visible to that request.
- R10: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and every region entry is invalid, so any request faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 48 | Virtual pointer to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_pa | output | 40 | Physical address (zero on fault) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Byte address of the 8-byte table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Table entry read back |
| cfg_we | input | 1 | Region table write strobe |
| cfg_idx | input | 2 | Region entry to write |
| cfg_vld | input | 1 | Valid flag for the written entry |
| cfg_tag | input | 7 | Region tag compared with pointer bits [47:41] |
| cfg_base | input | 40 | Physical base of the region's flat table |

## Verification
The hardest situations to create from the ports are those where timing alone decides the outcome. One is a region-table write that arrives during a walk. The stimulus stalls `mem_req_ready` so the walker stays parked with its first read pending. It then writes a conflicting entry and, after release, translates the same pointer again to show the old entry survived. The same stall window is used to inject a stray `mem_rsp_valid` carrying an all-ones entry, which would corrupt the result if taken. A write issued in the very cycle a request is accepted exercises the opposite ordering.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;
    // Address geometry
    localparam int VA_W    = 48;
    localparam int PA_W    = 40;
    localparam int ENT_W   = 64;
    localparam int PG_SH   = 12;
    localparam int TAG_HI  = 47;
    localparam int TAG_LO  = 41;
    localparam int FIX_HI  = 40;
    localparam int FIX_LO  = 21;
    localparam int SIX_HI  = 20;
    localparam int SIX_LO  = 12;
    localparam int TAG_W   = TAG_HI - TAG_LO + 1;
    localparam int FIX_W   = FIX_HI - FIX_LO + 1;
    localparam int SIX_W   = SIX_HI - SIX_LO + 1;
    localparam int ENT_SH  = $clog2(ENT_W / 8);
    localparam int RGN_DEF = 4;

    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_REGION = 3'd1,
        WS_FLAT   = 3'd2,
        WS_SMALL  = 3'd3,
        WS_DONE   = 3'd4
    } walk_st_e;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PA_W-1:0]  base;
    } rgn_ent_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [FIX_W-1:0] fidx;
        logic [SIX_W-1:0] sidx;
        logic [PG_SH-1:0] off;
    } va_t;

    // Byte address of entry idx in a table of 8-byte entries
    function automatic logic [PA_W-1:0] tab_addr(input logic [PA_W-1:0] base,
                                                 input logic [FIX_W-1:0] idx);
        return base + PA_W'({idx, {ENT_SH{1'b0}}});
    endfunction

    // Page-aligned pointer carried in a table entry
    function automatic logic [PA_W-1:0] ent_ptr(input logic [ENT_W-1:0] ent);
        return {ent[PA_W-1:PG_SH], {PG_SH{1'b0}}};
    endfunction
endpackage

// File: rtl/xw_region_table.sv
`timescale 1ns/1ps
module xw_region_table
    import xw_pkg::*;
#(
    parameter int NUM_RGN = RGN_DEF,
    localparam int IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rgn_ent_t         wr_ent,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [PA_W-1:0]  hit_base
);
    rgn_ent_t           ent_q [NUM_RGN];
    logic [NUM_RGN-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_RGN; i++) begin
                ent_q[i] <= '0;
            end
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_ent;
        end
    end

    // Parallel tag compare, one comparator per entry
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
        assign match[g] = ent_q[g].vld && (ent_q[g].tag == look_tag);
    end

    // Lowest index wins: scan from the top so the lowest overwrites
    always_comb begin
        hit      = 1'b0;
        hit_base = '0;
        for (int i = NUM_RGN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_base = ent_q[i].base;
            end
        end
    end
endmodule

// File: rtl/xw_addr_calc.sv
`timescale 1ns/1ps
module xw_addr_calc
    import xw_pkg::*;
(
    input  va_t              va,
    input  logic [PA_W-1:0]  rgn_base,
    input  logic [ENT_W-1:0] ent,
    output logic [PA_W-1:0]  flat_addr,
    output logic [PA_W-1:0]  small_addr,
    output logic [PA_W-1:0]  leaf_pa,
    output logic             ent_ok
);
    logic ent_unused;

    assign flat_addr  = tab_addr(rgn_base, va.fidx);
    assign small_addr = tab_addr(ent_ptr(ent), FIX_W'(va.sidx));
    assign leaf_pa    = {ent[PA_W-1:PG_SH], va.off};
    assign ent_ok     = ent[0];
    assign ent_unused = ^{ent[ENT_W-1:PA_W], ent[PG_SH-1:1]};
endmodule

// File: rtl/xw_walk_ctrl.sv
`timescale 1ns/1ps
module xw_walk_ctrl
    import xw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_va,
    output logic            req_ready,
    output va_t             va_q,
    input  logic            rgn_hit,
    input  logic [PA_W-1:0] flat_addr,
    input  logic [PA_W-1:0] small_addr,
    input  logic [PA_W-1:0] leaf_pa,
    input  logic            ent_ok,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_pa
);
    walk_st_e        state_q;
    logic            issued_q;
    logic [PA_W-1:0] addr_q;
    logic            fault_q;
    logic [PA_W-1:0] pa_q;
    logic            rd_wait;

    // A returned word only counts while a read is actually in flight
    assign rd_wait = (state_q == WS_FLAT || state_q == WS_SMALL) && issued_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WS_IDLE;
            va_q     <= '0;
            issued_q <= 1'b0;
            addr_q   <= '0;
            fault_q  <= 1'b0;
            pa_q     <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q    <= va_t'(req_va);
                        fault_q <= 1'b0;
                        pa_q    <= '0;
                        state_q <= WS_REGION;
                    end
                end
                WS_REGION: begin
                    issued_q <= 1'b0;
                    if (rgn_hit) begin
                        addr_q  <= flat_addr;
                        state_q <= WS_FLAT;
                    end else begin
                        fault_q <= 1'b1;
                        state_q <= WS_DONE;
                    end
                end
                WS_FLAT: begin
                    if (!issued_q) begin
                        if (mem_req_ready) issued_q <= 1'b1;
                    end else if (rd_wait && mem_rsp_valid) begin
                        if (ent_ok) begin
                            addr_q   <= small_addr;
                            issued_q <= 1'b0;
                            state_q  <= WS_SMALL;
                        end else begin
                            fault_q <= 1'b1;
                            state_q <= WS_DONE;
                        end
                    end
                end
                WS_SMALL: begin
                    if (!issued_q) begin
                        if (mem_req_ready) issued_q <= 1'b1;
                    end else if (rd_wait && mem_rsp_valid) begin
                        if (ent_ok) pa_q <= leaf_pa;
                        fault_q <= !ent_ok;
                        state_q <= WS_DONE;
                    end
                end
                WS_DONE: begin
                    state_q <= WS_IDLE;
                end
                default: begin
                    state_q <= WS_IDLE;
                end
            endcase
        end
    end

    assign req_ready     = (state_q == WS_IDLE);
    assign mem_req_valid = (state_q == WS_FLAT || state_q == WS_SMALL) && !issued_q;
    assign mem_req_addr  = addr_q;
    assign rsp_valid     = (state_q == WS_DONE);
    assign rsp_fault     = fault_q;
    assign rsp_pa        = pa_q;
endmodule

// File: rtl/xw_region_walker.sv
`timescale 1ns/1ps
module xw_region_walker
    import xw_pkg::*;
#(
    parameter int NUM_RGN = RGN_DEF,
    localparam int IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_vld,
    input  logic [TAG_W-1:0] cfg_tag,
    input  logic [PA_W-1:0]  cfg_base
);
    va_t             va_q;
    logic            rgn_hit;
    logic [PA_W-1:0] rgn_base;
    logic [PA_W-1:0] flat_addr;
    logic [PA_W-1:0] small_addr;
    logic [PA_W-1:0] leaf_pa;
    logic            ent_ok;
    logic            cfg_take;
    rgn_ent_t        cfg_ent;

    // Table updates only while idle, so a walk never sees a changing entry
    assign cfg_take = cfg_we && req_ready;
    assign cfg_ent  = '{vld: cfg_vld, tag: cfg_tag, base: cfg_base};

    xw_region_table #(.NUM_RGN(NUM_RGN)) rtab_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_take),
        .wr_idx   (cfg_idx),
        .wr_ent   (cfg_ent),
        .look_tag (va_q.tag),
        .hit      (rgn_hit),
        .hit_base (rgn_base)
    );

    xw_addr_calc acalc_i (
        .va         (va_q),
        .rgn_base   (rgn_base),
        .ent        (mem_rsp_data),
        .flat_addr  (flat_addr),
        .small_addr (small_addr),
        .leaf_pa    (leaf_pa),
        .ent_ok     (ent_ok)
    );

    xw_walk_ctrl wctl_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_va        (req_va),
        .req_ready     (req_ready),
        .va_q          (va_q),
        .rgn_hit       (rgn_hit),
        .flat_addr     (flat_addr),
        .small_addr    (small_addr),
        .leaf_pa       (leaf_pa),
        .ent_ok        (ent_ok),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_pa        (rsp_pa)
    );
endmodule

// File: rtl/xw_walker_chk.sv
`timescale 1ns/1ps
module xw_walker_chk
    import xw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);
    logic [PG_SH-1:0] off_q;
    logic             chk_unused;

    assign chk_unused = ^req_va[VA_W-1:PG_SH];

    always_ff @(posedge clk) begin
        if (rst) off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_va[PG_SH-1:0];
    end

    p_busy_after_acc_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready)
        else $error("R1: ready stayed high after accept");

    p_idle_after_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready)
        else $error("R1: not idle after response");

    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid)
        else $error("R7: response longer than one cycle");

    p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0))
        else $error("R7: fault with nonzero address");

    p_offset_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[PG_SH-1:0] == off_q))
        else $error("R6: page offset altered");

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
        else $error("R8: read request dropped or changed");

    p_no_read_idle_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid)
        else $error("R8: read while idle");
endmodule

bind xw_region_walker xw_walker_chk chk_i (.*);

// File: tb/xw_region_walker_tb_top.sv
`timescale 1ns/1ps
module xw_region_walker_tb_top;
    import xw_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_va = '0;
    logic             rsp_valid;
    logic             rsp_fault;
    logic [PA_W-1:0]  rsp_pa;
    logic             mem_req_valid;
    logic             mem_req_ready = 1'b1;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_rsp_valid = 1'b0;
    logic [ENT_W-1:0] mem_rsp_data = '0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_idx = '0;
    logic             cfg_vld = 1'b0;
    logic [TAG_W-1:0] cfg_tag = '0;
    logic [PA_W-1:0]  cfg_base = '0;

    always #2 clk = ~clk;

    xw_region_walker dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vld(cfg_vld),
        .cfg_tag(cfg_tag), .cfg_base(cfg_base)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [ENT_W-1:0] mem [logic [PA_W-1:0]];

    // Reference state
    bit              sh_vld [4];
    logic [6:0]      sh_tag [4];
    logic [PA_W-1:0] sh_base [4];
    bit              ref_busy = 0;
    bit              set_nx = 0;
    bit              clr_nx = 0;
    bit              e_fault;
    logic [PA_W-1:0] e_pa;
    logic [PA_W-1:0] e_addr [2];
    int              e_n = 0;
    int              e_i = 0;
    int              acc_cyc = 0;
    int              acc_req = 0;
    int              acc_done = 0;
    logic [PA_W-1:0] acc_addr;
    int              stray_req = 0;
    int              stray_done = 0;
    int              mem_lat = 1;
    bit              pend = 0;
    int              cnt = 0;
    logic [ENT_W-1:0] pdata;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [ENT_W-1:0] rd(input logic [PA_W-1:0] a);
        return mem.exists(a) ? mem[a] : '0;
    endfunction

    function automatic logic [VA_W-1:0] mk_va(input logic [6:0] t, input logic [19:0] f,
                                              input logic [8:0] s, input logic [11:0] o);
        return {t, f, s, o};
    endfunction

    function automatic logic [ENT_W-1:0] mk_ent(input logic [27:0] ptr, input bit v);
        return {24'h0, ptr, 11'h0, v};
    endfunction

    // Behavioural translation following R2..R6
    task automatic ref_walk(input logic [VA_W-1:0] va);
        int hit_i;
        logic [ENT_W-1:0] d;
        logic [PA_W-1:0] a;
        hit_i = -1;
        e_n = 0;
        e_i = 0;
        e_fault = 1;
        e_pa = '0;
        for (int i = 3; i >= 0; i--) begin
            if (sh_vld[i] && sh_tag[i] == va[47:41]) hit_i = i;
        end
        if (hit_i >= 0) begin
            a = sh_base[hit_i] + PA_W'(va[40:21]) * 8;
            e_addr[0] = a;
            e_n = 1;
            d = rd(a);
            if (d[0]) begin
                a = {d[39:12], 12'h000} + PA_W'(va[20:12]) * 8;
                e_addr[1] = a;
                e_n = 2;
                d = rd(a);
                if (d[0]) begin
                    e_fault = 0;
                    e_pa = {d[39:12], va[11:0]};
                end
            end
        end
    endtask

    // Monitor and reference comparison, once per cycle
    always @(negedge clk) begin
        string tg;
        cyc++;
        if (rst) begin
            ref_busy = 0;
            set_nx = 0;
            clr_nx = 0;
        end else begin
            if (clr_nx) ref_busy = 0;
            if (set_nx) ref_busy = 1;
            clr_nx = 0;
            set_nx = 0;
            chk(req_ready == !ref_busy, "R1", "req_ready", 64'(req_ready), 64'(!ref_busy));
            if (mem_req_valid) begin
                chk(e_i < e_n, "R8", "read beyond expected count", 64'(mem_req_addr), 64'(e_i));
                if (mem_req_ready && e_i < e_n) begin
                    chk(mem_req_addr == e_addr[e_i], (e_i == 0) ? "R3" : "R5",
                        "read address", 64'(mem_req_addr), 64'(e_addr[e_i]));
                    e_i++;
                    acc_addr = mem_req_addr;
                    acc_req++;
                end
            end
            if (cfg_we && req_ready) begin
                sh_vld[cfg_idx]  = cfg_vld;
                sh_tag[cfg_idx]  = cfg_tag;
                sh_base[cfg_idx] = cfg_base;
            end
            if (req_valid && req_ready) begin
                ref_walk(req_va);
                acc_cyc = cyc;
                set_nx = 1;
            end
            if (rsp_valid) begin
                tg = (e_n == 0) ? "R2" : ((e_n == 1) ? "R4" : "R6");
                chk(ref_busy, "R7", "response without request", 64'(rsp_valid), 64'(0));
                chk(rsp_fault == e_fault, tg, "fault flag", 64'(rsp_fault), 64'(e_fault));
                chk(rsp_pa == e_pa, tg, "physical address", 64'(rsp_pa), 64'(e_pa));
                chk(e_i == e_n, "R8", "reads issued", 64'(e_i), 64'(e_n));
                if (e_n == 0)
                    chk(cyc == acc_cyc + 2, "R2", "miss latency", 64'(cyc), 64'(acc_cyc + 2));
                clr_nx = 1;
            end
        end
    end

    // Memory model: one read in flight, programmable latency, stray injection
    always @(posedge clk) begin
        #1;
        mem_rsp_valid = 1'b0;
        if (rst) begin
            pend = 0;
            acc_done = acc_req;
            stray_done = stray_req;
        end else if (acc_done != acc_req) begin
            acc_done = acc_req;
            pend = 1;
            cnt = mem_lat;
            pdata = rd(acc_addr);
        end else if (pend) begin
            cnt--;
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = pdata;
                pend = 0;
            end
        end else if (stray_done != stray_req) begin
            stray_done = stray_req;
            mem_rsp_valid = 1'b1;
            mem_rsp_data = '1;
        end
    end

    task automatic wait_rsp();
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!rsp_valid && t < 500);
        chk(t < 500, "R7", "response timeout", 64'(t), 64'(500));
    endtask

    task automatic do_req(input logic [VA_W-1:0] va);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_va = va;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_rsp();
    endtask

    task automatic start_req(input logic [VA_W-1:0] va);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_va = va;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic cfg_write(input int idx, input bit v, input logic [6:0] t,
                             input logic [PA_W-1:0] b);
        @(posedge clk); #1;
        cfg_we = 1'b1;
        cfg_idx = 2'(idx);
        cfg_vld = v;
        cfg_tag = t;
        cfg_base = b;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    localparam logic [PA_W-1:0] RB0 = 40'h00_4000_0000;
    localparam logic [PA_W-1:0] RB1 = 40'h00_5000_0000;
    localparam logic [PA_W-1:0] RB2 = 40'h00_6000_0000;
    localparam logic [PA_W-1:0] RB3 = 40'h00_7000_0000;

    initial begin
        logic [VA_W-1:0] va_a, va_b, va_c, va_d, va_e, va_m;
        va_a = mk_va(7'h05, 20'h00003, 9'h011, 12'hABC);
        va_b = mk_va(7'h05, 20'hFFFFF, 9'h1FF, 12'hFFF);
        va_c = mk_va(7'h05, 20'h00011, 9'h002, 12'h123);
        va_d = mk_va(7'h05, 20'h00012, 9'h005, 12'h456);
        va_e = mk_va(7'h33, 20'h00001, 9'h001, 12'h789);
        va_m = mk_va(7'h44, 20'h00003, 9'h011, 12'hABC);

        // Table contents
        mem[RB0 + 40'h18]              = mk_ent(28'h0000800, 1'b1);
        mem[40'h00_0080_0000 + 40'h88] = mk_ent(28'h0123456, 1'b1);
        mem[RB0 + 40'h7F_FFF8]         = mk_ent(28'h0000900, 1'b1);
        mem[40'h00_0090_0000 + 40'hFF8] = mk_ent(28'hFEDCBA9, 1'b1);
        mem[RB0 + 40'h88]              = mk_ent(28'h0000A00, 1'b0);
        mem[40'h00_00A0_0000 + 40'h10] = mk_ent(28'h0BADBAD, 1'b1);
        mem[RB0 + 40'h90]              = mk_ent(28'h0000B00, 1'b1);
        mem[40'h00_00B0_0000 + 40'h28] = mk_ent(28'h0777777, 1'b0);
        mem[RB2 + 40'h8]               = mk_ent(28'h0000C00, 1'b1);
        mem[40'h00_00C0_0000 + 40'h8]  = mk_ent(28'h0C0FFEE, 1'b1);
        mem[RB3 + 40'h8]               = mk_ent(28'h0000D00, 1'b1);
        mem[40'h00_00D0_0000 + 40'h8]  = mk_ent(28'h0D00D00, 1'b1);
        for (int i = 0; i < 4; i++) begin
            sh_vld[i] = 0;
            sh_tag[i] = '0;
            sh_base[i] = '0;
        end

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'(1));
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
        chk(mem_req_valid == 1'b0, "R10", "mem_req_valid after reset", 64'(mem_req_valid), 64'(0));

        // R10: empty table faults every request
        do_req(va_a);
        chk(rsp_fault == 1'b1, "R10", "empty table fault", 64'(rsp_fault), 64'(1));

        // R3 R5 R6: full walks, including top index values
        cfg_write(0, 1'b1, 7'h05, RB0);
        do_req(va_a);
        chk(rsp_pa == 40'h01_2345_6ABC, "R6", "walk result", 64'(rsp_pa), 64'h01_2345_6ABC);
        do_req(va_b);
        chk(rsp_pa == 40'hFE_DCBA_9FFF, "R5", "max index walk", 64'(rsp_pa), 64'hFE_DCBA_9FFF);

        // R4 invalid flat entry, R6 invalid last-level entry
        do_req(va_c);
        chk(rsp_fault == 1'b1, "R4", "invalid flat entry", 64'(rsp_fault), 64'(1));
        do_req(va_d);
        chk(rsp_fault == 1'b1, "R6", "invalid leaf entry", 64'(rsp_fault), 64'(1));

        // R2: unmatched tag, then lowest index priority
        do_req(va_e);
        chk(rsp_fault == 1'b1, "R2", "no region match", 64'(rsp_fault), 64'(1));
        cfg_write(3, 1'b1, 7'h33, RB3);
        cfg_write(2, 1'b1, 7'h33, RB2);
        do_req(va_e);
        chk(rsp_pa == 40'h0C_0FFE_E789, "R2", "lowest entry wins", 64'(rsp_pa), 64'h0C_0FFE_E789);

        // R8: stalled request, longer latency, stray response while nothing in flight
        mem_lat = 3;
        mem_req_ready = 1'b0;
        start_req(va_a);
        repeat (2) @(negedge clk);
        stray_req++;
        repeat (4) @(negedge clk);
        chk(mem_req_valid == 1'b1, "R8", "request held under stall", 64'(mem_req_valid), 64'(1));
        @(posedge clk); #1;
        mem_req_ready = 1'b1;
        wait_rsp();
        chk(rsp_pa == 40'h01_2345_6ABC, "R8", "stray data ignored", 64'(rsp_pa), 64'h01_2345_6ABC);

        // R9: write while busy is dropped
        mem_lat = 2;
        mem_req_ready = 1'b0;
        start_req(va_a);
        cfg_write(0, 1'b1, 7'h7F, RB1);
        @(posedge clk); #1;
        mem_req_ready = 1'b1;
        wait_rsp();
        do_req(va_a);
        chk(rsp_fault == 1'b0 && rsp_pa == 40'h01_2345_6ABC, "R9", "busy write dropped",
            64'(rsp_pa), 64'h01_2345_6ABC);

        // R9: write in the accepting cycle is seen by that request
        mem_lat = 1;
        @(posedge clk); #1;
        cfg_we = 1'b1;
        cfg_idx = 2'd1;
        cfg_vld = 1'b1;
        cfg_tag = 7'h44;
        cfg_base = RB0;
        req_valid = 1'b1;
        req_va = va_m;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        req_valid = 1'b0;
        wait_rsp();
        chk(rsp_fault == 1'b0 && rsp_pa == 40'h01_2345_6ABC, "R9", "same-cycle write",
            64'(rsp_pa), 64'h01_2345_6ABC);

        // R2: invalidated entry no longer matches
        cfg_write(1, 1'b0, 7'h44, RB0);
        do_req(va_m);
        chk(rsp_fault == 1'b1, "R2", "invalidated entry", 64'(rsp_fault), 64'(1));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(negedge clk) begin
        if (!finished && cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule